// File: doc/BRIEF.md
# Programmable Per-Cycle Timing Edge Generator

This block lays out the timing inside every tester cycle. A fine-timebase tick counter runs from zero up to the last tick of the active cycle, then reloads. At each tick, the block compares the counter with a table of programmed edge offsets. It emits a one-clock cycle-start pulse, four drive-edge pulses that tell a vector engine when to change the device inputs, and two compare-strobe pulses that tell it when to sample the device outputs. All offsets are whole ticks of the fine timebase.

Four waveform sets sit in registers. Each set holds a cycle length together with its own drive and strobe offsets. A set-select input picks the set for the following cycle, and the new choice is taken only at a cycle boundary. A cycle length and its matching late strobe therefore always switch together. This lets a run alternate or step through shrinking periods, each with its own strobe, to find where the device under test starts to fail. A write port loads the registers. A running cycle count and a sticky flag for offsets outside their cycle complete the outputs.

Top module: `cycle_edge_gen`

## Requirements
- R1: While `rst_n` is low, all pulse outputs, `cycle_cnt_o` and `cfg_err_o` are 0. Every set resets to last tick index 15, drive offsets 0 and strobe offsets 15. The first cycle after reset always uses set 0, whatever `set_sel_i` holds.
- R2: A cycle of a set whose last-tick field is L lasts L+1 clocks. `cyc_start_o` is high in exactly the first clock (tick 0) of each cycle. The first cycle begins in the second clock after `rst_n` rises.
- R3: Drive edge i (`drive_o[i]`, i = 0..3) is high for one clock, in the tick of the cycle equal to its programmed offset.
- R4: Strobe j (`strobe_o[j]`, j = 0..1) is high for one clock, in the tick of the cycle equal to its programmed offset.
- R5: `set_sel_i` is sampled only at the rising edge that ends a cycle, and that value picks the set for the next cycle. Changes at any other time do not alter the running cycle's length or edges.
- R6: An edge whose offset is greater than the active set's last tick index never pulses. If the active set holds any such offset, `cfg_err_o` rises in the clock after that cycle's tick 0 and stays high until reset.
- R7: `cycle_cnt_o` is 0 during the first cycle and rises by one at each cycle boundary, wrapping modulo 2^CW.
- R8: When `cfg_we_i` is high at a rising edge, `cfg_data_i` is written into set `cfg_set_i` at field `cfg_field_i`. The field codes are: 0 for the last tick index, 1 to 4 for drive offsets 0 to 3, and 5 to 6 for strobe offsets 0 to 1. The new value is used from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine timebase clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_sel_i | input | SW (2) | Waveform set wanted for the next cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_set_i | input | SW (2) | Set addressed by a write |
| cfg_field_i | input | FW (3) | Field addressed by a write |
| cfg_data_i | input | TW (16) | Value written |
| cyc_start_o | output | 1 | High in tick 0 of every cycle |
| drive_o | output | ND (4) | Drive-edge pulses |
| strobe_o | output | NC (2) | Compare-strobe pulses |
| cycle_cnt_o | output | CW (16) | Cycles begun since reset, modulo 2^CW |
| cfg_err_o | output | 1 | Sticky flag for an offset beyond its cycle |

## Verification
The hardest case to reach from the ports is a set switch at the exact boundary while `set_sel_i` moves in the middle of the cycle. The registers of the next set are also being rewritten during an earlier cycle. To get there, the stimulus drives a wrong selection on the first tick of every cycle and the right one only in the last tick. It loads three sets of different lengths while the default set runs, and then alternates the sets cycle by cycle. A fourth set with out-of-range offsets is used late in the run, so that the sticky flag must rise one clock into that cycle and hold through later valid cycles. The cycle counter is narrowed so that it wraps within the run.

// File: rtl/cycle_edge_pkg.sv
package cycle_edge_pkg;

  typedef enum logic [1:0] {
    FK_LAST   = 2'd0,
    FK_DRIVE  = 2'd1,
    FK_STROBE = 2'd2,
    FK_NONE   = 2'd3
  } field_kind_e;

  // Field 0 holds the last tick index, then drive offsets, then strobe offsets.
  function automatic field_kind_e field_kind(int f, int nd, int nc);
    if (f == 0)              return FK_LAST;
    else if (f <= nd)        return FK_DRIVE;
    else if (f <= nd + nc)   return FK_STROBE;
    else                     return FK_NONE;
  endfunction

  // Edge slot addressed by an offset field (drives first, strobes after).
  function automatic int field_edge(int f);
    return f - 1;
  endfunction

endpackage

// File: rtl/cycle_edge_regs.sv
module cycle_edge_regs
  import cycle_edge_pkg::*;
#(
  parameter int NSET     = 4,
  parameter int ND       = 4,
  parameter int NC       = 2,
  parameter int TW       = 16,
  parameter int SW       = 2,
  parameter int FW       = 3,
  parameter int DEF_LAST = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SW-1:0]              wset,
  input  logic [FW-1:0]              wfield,
  input  logic [TW-1:0]              wdata,
  input  logic [SW-1:0]              rset,
  output logic [TW-1:0]              rlast,
  output logic [ND+NC-1:0][TW-1:0]   roff
);
  localparam int NE = ND + NC;

  logic [NSET-1:0][TW-1:0]         last_all;
  logic [NSET-1:0][NE-1:0][TW-1:0] off_all;

  field_kind_e kind_w;
  int          edge_w;
  assign kind_w = field_kind(int'(wfield), ND, NC);
  assign edge_w = field_edge(int'(wfield));

  for (genvar s = 0; s < NSET; s++) begin : g_set
    logic                   sel_w;
    logic [TW-1:0]          last_r;
    logic [NE-1:0][TW-1:0]  off_r;

    assign sel_w = we && (wset == SW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_r <= TW'(DEF_LAST);
        for (int e = 0; e < NE; e++)
          off_r[e] <= (e < ND) ? '0 : TW'(DEF_LAST);
      end else if (sel_w) begin
        if (kind_w == FK_LAST)
          last_r <= wdata;
        for (int e = 0; e < NE; e++)
          if ((kind_w == FK_DRIVE || kind_w == FK_STROBE) && edge_w == e)
            off_r[e] <= wdata;
      end
    end

    assign last_all[s] = last_r;
    assign off_all[s]  = off_r;
  end

  assign rlast = last_all[rset];
  assign roff  = off_all[rset];

endmodule

// File: rtl/cycle_tick_seq.sv
module cycle_tick_seq #(
  parameter int TW = 16,
  parameter int SW = 2,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] last,
  input  logic [SW-1:0] set_sel,
  output logic [TW-1:0] tick,
  output logic [SW-1:0] act_set,
  output logic          run,
  output logic          wrap,
  output logic          cyc_start,
  output logic [CW-1:0] cycle_cnt
);
  logic [TW-1:0] tick_q;
  logic [SW-1:0] act_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  // A cycle ends on its last tick; ">=" also ends a cycle whose length was cut below the count.
  function automatic logic at_end(logic [TW-1:0] t, logic [TW-1:0] l);
    return t >= l;
  endfunction

  assign wrap      = run_q && at_end(tick_q, last);
  assign cyc_start = run_q && (tick_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (wrap) begin
          tick_q <= '0;
          act_q  <= set_sel;
          cnt_q  <= cnt_q + CW'(1);
        end else begin
          tick_q <= tick_q + TW'(1);
        end
      end
    end
  end

  assign tick      = tick_q;
  assign act_set   = act_q;
  assign run       = run_q;
  assign cycle_cnt = cnt_q;

endmodule

// File: rtl/cycle_edge_match.sv
module cycle_edge_match #(
  parameter int TW = 16,
  parameter int NE = 6
) (
  input  logic                  run,
  input  logic [TW-1:0]         tick,
  input  logic [TW-1:0]         last,
  input  logic [NE-1:0][TW-1:0] off,
  output logic [NE-1:0]         hit,
  output logic [NE-1:0]         bad
);
  function automatic logic out_of_cycle(logic [TW-1:0] o, logic [TW-1:0] l);
    return o > l;
  endfunction

  function automatic logic fires(logic [TW-1:0] t, logic [TW-1:0] o, logic [TW-1:0] l);
    return !out_of_cycle(o, l) && (t == o);
  endfunction

  for (genvar e = 0; e < NE; e++) begin : g_edge
    assign bad[e] = out_of_cycle(off[e], last);
    assign hit[e] = run && fires(tick, off[e], last);
  end

endmodule

// File: rtl/cycle_edge_gen.sv
module cycle_edge_gen #(
  parameter int NSET     = 4,
  parameter int ND       = 4,
  parameter int NC       = 2,
  parameter int TW       = 16,
  parameter int CW       = 16,
  parameter int DEF_LAST = 15,
  parameter int SW       = $clog2(NSET),
  parameter int FW       = $clog2(ND + NC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_sel_i,
  input  logic          cfg_we_i,
  input  logic [SW-1:0] cfg_set_i,
  input  logic [FW-1:0] cfg_field_i,
  input  logic [TW-1:0] cfg_data_i,
  output logic          cyc_start_o,
  output logic [ND-1:0] drive_o,
  output logic [NC-1:0] strobe_o,
  output logic [CW-1:0] cycle_cnt_o,
  output logic          cfg_err_o
);
  localparam int NE = ND + NC;

  logic [TW-1:0]         tick_w;
  logic [TW-1:0]         last_w;
  logic [SW-1:0]         act_w;
  logic                  run_w;
  logic                  wrap_w;
  logic                  start_w;
  logic [NE-1:0][TW-1:0] off_w;
  logic [NE-1:0]         hit_w;
  logic [NE-1:0]         bad_w;
  logic                  err_q;

  cycle_edge_regs #(
    .NSET(NSET), .ND(ND), .NC(NC), .TW(TW), .SW(SW), .FW(FW), .DEF_LAST(DEF_LAST)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we_i),
    .wset   (cfg_set_i),
    .wfield (cfg_field_i),
    .wdata  (cfg_data_i),
    .rset   (act_w),
    .rlast  (last_w),
    .roff   (off_w)
  );

  cycle_tick_seq #(.TW(TW), .SW(SW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .last      (last_w),
    .set_sel   (set_sel_i),
    .tick      (tick_w),
    .act_set   (act_w),
    .run       (run_w),
    .wrap      (wrap_w),
    .cyc_start (start_w),
    .cycle_cnt (cycle_cnt_o)
  );

  cycle_edge_match #(.TW(TW), .NE(NE)) u_match (
    .run  (run_w),
    .tick (tick_w),
    .last (last_w),
    .off  (off_w),
    .hit  (hit_w),
    .bad  (bad_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err_q <= 1'b0;
    else if (start_w && |bad_w) err_q <= 1'b1;
  end

  assign cyc_start_o = start_w;
  assign drive_o     = hit_w[ND-1:0];
  assign strobe_o    = hit_w[NE-1:ND];
  assign cfg_err_o   = err_q;

endmodule

// File: rtl/cycle_edge_gen_chk.sv
module cycle_edge_gen_chk #(
  parameter int TW = 16,
  parameter int SW = 2,
  parameter int CW = 16,
  parameter int NE = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          wrap,
  input logic          cyc_start,
  input logic [SW-1:0] act_set,
  input logic [CW-1:0] cycle_cnt,
  input logic          err,
  input logic [NE-1:0] pulses,
  input logic [NE-1:0] bad
);
  assert_first_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cyc_start);

  assert_start_after_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cyc_start);

  assert_set_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_set));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cycle_cnt == $past(cycle_cnt) + CW'(1)));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cycle_cnt));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_no_bad_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pulses & bad)));

  assert_err_needs_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cyc_start && |bad));

endmodule

bind cycle_edge_gen cycle_edge_gen_chk #(.TW(TW), .SW(SW), .CW(CW), .NE(ND + NC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_w),
  .wrap      (wrap_w),
  .cyc_start (start_w),
  .act_set   (act_w),
  .cycle_cnt (cycle_cnt_o),
  .err       (err_q),
  .pulses    (hit_w),
  .bad       (bad_w)
);

// File: tb/cycle_edge_gen_tb_top.sv
module cycle_edge_gen_tb_top;
  localparam int CWB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] set_sel = 2'd2;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_set = '0;
  logic [2:0] cfg_field = '0;
  logic [15:0] cfg_data = '0;

  logic           cyc_start;
  logic [3:0]     drive;
  logic [1:0]     strobe;
  logic [CWB-1:0] cycle_cnt;
  logic           cfg_err;

  always #4 clk = ~clk;

  cycle_edge_gen #(.CW(CWB)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_sel_i(set_sel),
    .cfg_we_i(cfg_we), .cfg_set_i(cfg_set), .cfg_field_i(cfg_field), .cfg_data_i(cfg_data),
    .cyc_start_o(cyc_start), .drive_o(drive), .strobe_o(strobe),
    .cycle_cnt_o(cycle_cnt), .cfg_err_o(cfg_err)
  );

  typedef struct packed {
    logic           start;
    logic [3:0]     drv;
    logic [1:0]     cmp;
    logic [CWB-1:0] cnt;
    logic           err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // shadow of the programmed sets
  int last_s[4];
  int off_s[4][6];
  bit err_exp = 0;

  int wq_set[$];
  int wq_fld[$];
  int wq_dat[$];

  task automatic fail(string req, string what, int act, int expv);
    n_bad++;
    $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
  endtask

  task automatic queue_set(int s, int l, int d0, int d1, int d2, int d3, int c0, int c1);
    int v[7];
    v = '{l, d0, d1, d2, d3, c0, c1};
    for (int f = 0; f < 7; f++) begin
      wq_set.push_back(s); wq_fld.push_back(f); wq_dat.push_back(v[f]);
    end
    last_s[s] = l;
    off_s[s] = '{d0, d1, d2, d3, c0, c1};
  endtask

  // expected outputs for one whole cycle of set s
  task automatic push_cycle(int s, int idx, string tag);
    bit bad = 0;
    for (int e = 0; e < 6; e++) if (off_s[s][e] > last_s[s]) bad = 1;
    for (int t = 0; t <= last_s[s]; t++) begin
      exp_t x;
      x.start = (t == 0);
      for (int e = 0; e < 4; e++) x.drv[e] = (off_s[s][e] <= last_s[s]) && (t == off_s[s][e]);
      for (int e = 0; e < 2; e++) x.cmp[e] = (off_s[s][4+e] <= last_s[s]) && (t == off_s[s][4+e]);
      x.cnt = CWB'(idx % (1 << CWB));
      x.err = err_exp || (bad && t >= 1);
      exp_q.push_back(x);
      tag_q.push_back(tag);
    end
    if (bad) err_exp = 1;
  endtask

  // monitor: one expected vector per clock, compared at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  x;
      string tg;
      x  = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_vec++;
      if (cyc_start !== x.start) fail({"R2 ", tg}, "cyc_start", int'(cyc_start), int'(x.start));
      if (drive     !== x.drv)   fail({"R3 ", tg}, "drive",     int'(drive),     int'(x.drv));
      if (strobe    !== x.cmp)   fail({"R4 ", tg}, "strobe",    int'(strobe),    int'(x.cmp));
      if (cycle_cnt !== x.cnt)   fail({"R7 ", tg}, "cycle_cnt", int'(cycle_cnt), int'(x.cnt));
      if (cfg_err   !== x.err)   fail({"R6 ", tg}, "cfg_err",   int'(cfg_err),   int'(x.err));
    end
  end

  initial begin
    int seq[20];
    seq = '{0, 0, 1, 2, 1, 2, 2, 1, 0, 1, 2, 0, 1, 2, 1, 2, 3, 0, 1, 2};
    for (int s = 0; s < 4; s++) begin
      last_s[s] = 15;
      off_s[s] = '{0, 0, 0, 0, 15, 15};
    end

    // R1: reset state observed at the ports
    repeat (2) @(negedge clk);
    n_vec++;
    if ({cyc_start, drive, strobe} !== '0) fail("R1", "pulses in reset", int'({cyc_start, drive, strobe}), 0);
    if (cycle_cnt !== '0) fail("R1", "cycle_cnt in reset", int'(cycle_cnt), 0);
    if (cfg_err !== 1'b0) fail("R1", "cfg_err in reset", int'(cfg_err), 0);
    #1 rst_n = 1'b1;

    // R8: sets 1..3 are loaded while set 0 runs its default cycles
    queue_set(1, 11, 0, 2, 5, 11, 10, 3);
    queue_set(2, 9, 0, 1, 1, 9, 8, 9);
    queue_set(3, 7, 0, 3, 12, 6, 7, 20);
    // the shadow for set 0 keeps its reset defaults (R1)
    last_s[0] = 15;
    off_s[0] = '{0, 0, 0, 0, 15, 15};

    for (int i = 0; i < 20; i++) begin
      int len;
      int nxt;
      string tg;
      nxt = (i < 19) ? seq[i+1] : 0;
      len = last_s[seq[i]] + 1;
      tg  = (i < 2) ? "R1" : ((i == 2) ? "R8" : "R5");
      push_cycle(seq[i], i, tg);
      for (int j = 0; j < len; j++) begin
        @(negedge clk); #1;
        if (j == 0) set_sel = 2'((nxt + 1) % 4);   // R5: wrong choice mid-cycle
        if (wq_set.size() > 0) begin
          cfg_we    = 1'b1;
          cfg_set   = 2'(wq_set.pop_front());
          cfg_field = 3'(wq_fld.pop_front());
          cfg_data  = 16'(wq_dat.pop_front());
        end else begin
          cfg_we = 1'b0;
        end
        if (j == len - 1) set_sel = 2'(nxt);
      end
    end
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) fail("R2", "unconsumed vectors", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule